// File: doc/BRIEF.md
# Operand Bypass Selector

This block picks, for each source operand of the instruction now in the execute stage of a five-stage integer pipeline, where that operand's value should come from. There are three candidates: the register file, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. The block compares the register numbers the execute-stage instruction reads against the destinations of the two older instructions still in flight. It does this for both ALU inputs and for the register whose value a store writes to memory.

The two pipeline-register fields that matter are held inside the block: write enable, destination and result. A clock enable advances them by one stage. On the step into the memory/writeback register, a load's memory data replaces its ALU output. The operand muxes are included, so the block delivers finished operand values alongside the select codes. Stalling, branch handling, the register file and the ALU stay outside.

Top module: `bypass_unit`

## Requirements
- R1: After reset, both held stages have write enable cleared, so every select reads 2'b00 and every operand equals its register-file input.
- R2: When the execute/memory stage holds a write to a source's register, that source's select is 2'b10 and its operand is the execute/memory result.
- R3: When only the memory/writeback stage holds a write to a source's register, that source's select is 2'b01 and its operand is the memory/writeback result. This serves a consumer two instructions behind its producer.
- R4: When both stages write a source's register, the younger execute/memory result wins with select 2'b10.
- R5: A stage whose write enable is low never matches, whatever its destination.
- R6: Destination register 0 never matches. A source numbered 0 therefore always takes the register-file value with select 2'b00.
- R7: The store-data operand uses the same selection and priority as the two ALU operands, through its own select and operand outputs.
- R8: A load's memory data input, sampled when the load moves from execute/memory to memory/writeback, becomes that stage's forwarded result in place of its ALU output.
- R9: While the advance enable is low, both held stages keep their contents, so an unchanged source sees an unchanged operand.
- R10: With no match, the select is 2'b00 and the operand equals the register-file input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance both held stages by one step |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_rd_i | input | 5 | Execute-stage destination register |
| ex_res_i | input | 64 | Execute-stage ALU result |
| ex_ld_i | input | 1 | Execute-stage instruction is a load |
| ld_data_i | input | 64 | Data loaded in the memory stage |
| src_a_i | input | 5 | Register read as ALU operand A |
| src_b_i | input | 5 | Register read as ALU operand B |
| src_s_i | input | 5 | Register read as store data |
| rf_a_i | input | 64 | Register-file value for operand A |
| rf_b_i | input | 64 | Register-file value for operand B |
| rf_s_i | input | 64 | Register-file value for store data |
| sel_a_o | output | 2 | Source select for operand A |
| sel_b_o | output | 2 | Source select for operand B |
| sel_s_o | output | 2 | Source select for store data |
| opnd_a_o | output | 64 | Chosen operand A |
| opnd_b_o | output | 64 | Chosen operand B |
| opnd_s_o | output | 64 | Chosen store data |

## Verification
A corrupted held destination or write enable appears at the ports in the first cycle a matching source is presented. It shows up as a wrong select code and a stale operand in that same cycle. A bad result value, or a load data capture that took the wrong value, stays hidden until a consumer reads that register. It then surfaces only on the operand output while the select still looks right, so the checks compare both outputs. A broken advance enable shows up one step later, as a producer that is never seen or a stage that moves while it should hold.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    BYP_RF = 2'b00,
    BYP_MW = 2'b01,
    BYP_XM = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/byp_stage_reg.sv
module byp_stage_reg #(
  parameter int RW = 5,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we_d,
  input  logic [RW-1:0] rd_d,
  input  logic [DW-1:0] val_d,
  output logic          we_q,
  output logic [RW-1:0] rd_q,
  output logic [DW-1:0] val_q
);
  logic          we_n;
  logic [RW-1:0] rd_n;
  logic [DW-1:0] val_n;

  always_comb begin
    we_n  = we_q;
    rd_n  = rd_q;
    val_n = val_q;
    if (en) begin
      we_n  = we_d;
      rd_n  = rd_d;
      val_n = val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      rd_q  <= '0;
      val_q <= '0;
    end else begin
      we_q  <= we_n;
      rd_q  <= rd_n;
      val_q <= val_n;
    end
  end
endmodule

// File: rtl/byp_pick.sv
module byp_pick #(
  parameter int RW = 5
) (
  input  logic          [RW-1:0] src,
  input  logic                   xm_we,
  input  logic          [RW-1:0] xm_rd,
  input  logic                   mw_we,
  input  logic          [RW-1:0] mw_rd,
  output byp_pkg::byp_sel_e      sel
);
  logic xm_hit, mw_hit;

  always_comb begin
    xm_hit = xm_we && (xm_rd != '0) && (xm_rd == src);
    mw_hit = mw_we && (mw_rd != '0) && (mw_rd == src);
    if (xm_hit)      sel = byp_pkg::BYP_XM;
    else if (mw_hit) sel = byp_pkg::BYP_MW;
    else             sel = byp_pkg::BYP_RF;
  end
endmodule

// File: rtl/byp_mux.sv
module byp_mux #(
  parameter int DW = 64
) (
  input  byp_pkg::byp_sel_e          sel,
  input  logic              [DW-1:0] rf,
  input  logic              [DW-1:0] xm,
  input  logic              [DW-1:0] mw,
  output logic              [DW-1:0] y
);
  always_comb begin
    case (sel)
      byp_pkg::BYP_XM: y = xm;
      byp_pkg::BYP_MW: y = mw;
      default:         y = rf;
    endcase
  end
endmodule

// File: rtl/bypass_unit.sv
module bypass_unit #(
  parameter int RW = 5,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          ex_we_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic [DW-1:0] ex_res_i,
  input  logic          ex_ld_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [RW-1:0] src_a_i,
  input  logic [RW-1:0] src_b_i,
  input  logic [RW-1:0] src_s_i,
  input  logic [DW-1:0] rf_a_i,
  input  logic [DW-1:0] rf_b_i,
  input  logic [DW-1:0] rf_s_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic [1:0]    sel_s_o,
  output logic [DW-1:0] opnd_a_o,
  output logic [DW-1:0] opnd_b_o,
  output logic [DW-1:0] opnd_s_o
);
  localparam int NOP = 3;

  logic          xm_we, mw_we, xm_ld, xm_ld_n;
  logic [RW-1:0] xm_rd, mw_rd;
  logic [DW-1:0] xm_val, mw_val, mw_d;

  // Execute/memory stage
  byp_stage_reg #(.RW(RW), .DW(DW)) u_xm (
    .clk(clk), .rst_n(rst_n), .en(adv_i),
    .we_d(ex_we_i), .rd_d(ex_rd_i), .val_d(ex_res_i),
    .we_q(xm_we), .rd_q(xm_rd), .val_q(xm_val)
  );

  always_comb begin
    xm_ld_n = xm_ld;
    if (adv_i) xm_ld_n = ex_ld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xm_ld <= 1'b0;
    else        xm_ld <= xm_ld_n;
  end

  // R8: a load carries its memory data into the writeback stage
  always_comb mw_d = xm_ld ? ld_data_i : xm_val;

  byp_stage_reg #(.RW(RW), .DW(DW)) u_mw (
    .clk(clk), .rst_n(rst_n), .en(adv_i),
    .we_d(xm_we), .rd_d(xm_rd), .val_d(mw_d),
    .we_q(mw_we), .rd_q(mw_rd), .val_q(mw_val)
  );

  logic [NOP-1:0][RW-1:0] src_v;
  logic [NOP-1:0][DW-1:0] rf_v, op_v;
  logic [NOP-1:0][1:0]    sel_v;

  assign src_v = {src_s_i, src_b_i, src_a_i};
  assign rf_v  = {rf_s_i, rf_b_i, rf_a_i};

  for (genvar g = 0; g < NOP; g++) begin : g_op
    byp_pkg::byp_sel_e sel_g;
    byp_pick #(.RW(RW)) u_pick (
      .src(src_v[g]), .xm_we(xm_we), .xm_rd(xm_rd),
      .mw_we(mw_we), .mw_rd(mw_rd), .sel(sel_g)
    );
    byp_mux #(.DW(DW)) u_mux (
      .sel(sel_g), .rf(rf_v[g]), .xm(xm_val), .mw(mw_val), .y(op_v[g])
    );
    assign sel_v[g] = sel_g;
  end

  assign sel_a_o  = sel_v[0];
  assign sel_b_o  = sel_v[1];
  assign sel_s_o  = sel_v[2];
  assign opnd_a_o = op_v[0];
  assign opnd_b_o = op_v[1];
  assign opnd_s_o = op_v[2];
endmodule

// File: rtl/byp_checker.sv
module byp_checker #(
  parameter int RW = 5,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_i,
  input logic          ex_we_i,
  input logic [RW-1:0] ex_rd_i,
  input logic [DW-1:0] ex_res_i,
  input logic [RW-1:0] src_a_i,
  input logic [RW-1:0] src_s_i,
  input logic [DW-1:0] rf_a_i,
  input logic [DW-1:0] rf_b_i,
  input logic [RW-1:0] src_b_i,
  input logic [1:0]    sel_a_o,
  input logic [1:0]    sel_b_o,
  input logic [1:0]    sel_s_o,
  input logic [DW-1:0] opnd_a_o,
  input logic [DW-1:0] opnd_b_o,
  input logic [DW-1:0] opnd_s_o
);
  logic up1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up1 <= 1'b0;
    else        up1 <= 1'b1;
  end

  // R2 and R4: last step's producer wins for operand A
  a_r2_xm_select: assert property (@(posedge clk) disable iff (!rst_n)
    (up1 && $past(adv_i) && $past(ex_we_i) && $past(ex_rd_i) != '0 && src_a_i == $past(ex_rd_i))
    |-> (sel_a_o == 2'b10 && opnd_a_o == $past(ex_res_i)));

  // R7: same for the store-data path
  a_r7_store_select: assert property (@(posedge clk) disable iff (!rst_n)
    (up1 && $past(adv_i) && $past(ex_we_i) && $past(ex_rd_i) != '0 && src_s_i == $past(ex_rd_i))
    |-> (sel_s_o == 2'b10 && opnd_s_o == $past(ex_res_i)));

  // R6: register 0 never forwarded
  a_r6_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b_i == '0) |-> (sel_b_o == 2'b00 && opnd_b_o == rf_b_i));

  // R10: a register-file select delivers the register-file value
  a_r10_rf_path: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_o == 2'b00) |-> (opnd_a_o == rf_a_i));

  // R9: holding stages keep an unchanged source's operand unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up1 && !$past(adv_i) && $stable(src_a_i) && $stable(rf_a_i))
    |-> ($stable(opnd_a_o) && $stable(sel_a_o)));

  // R4: a select code never names both stages
  a_r4_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_a_o) && $onehot0(sel_b_o) && $onehot0(sel_s_o));
endmodule

bind bypass_unit byp_checker #(.RW(RW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .ex_we_i(ex_we_i),
  .ex_rd_i(ex_rd_i), .ex_res_i(ex_res_i), .src_a_i(src_a_i),
  .src_s_i(src_s_i), .rf_a_i(rf_a_i), .rf_b_i(rf_b_i), .src_b_i(src_b_i),
  .sel_a_o(sel_a_o), .sel_b_o(sel_b_o), .sel_s_o(sel_s_o),
  .opnd_a_o(opnd_a_o), .opnd_b_o(opnd_b_o), .opnd_s_o(opnd_s_o)
);

// File: tb/tb_bypass_unit.sv
module tb_bypass_unit;
  localparam int RW = 5;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, adv_i, ex_we_i, ex_ld_i;
  logic [RW-1:0] ex_rd_i, src_a_i, src_b_i, src_s_i;
  logic [DW-1:0] ex_res_i, ld_data_i, rf_a_i, rf_b_i, rf_s_i;
  logic [1:0]    sel_a_o, sel_b_o, sel_s_o;
  logic [DW-1:0] opnd_a_o, opnd_b_o, opnd_s_o;

  bypass_unit #(.RW(RW), .DW(DW)) dut (.*);

  typedef struct {
    logic [1:0]    sa, sb, ss;
    logic [DW-1:0] oa, ob, os;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, stepno = 0;

  // bench view of the held stages, from the requirements
  logic          m_xwe, m_mwe, m_xld;
  logic [RW-1:0] m_xrd, m_mrd;
  logic [DW-1:0] m_xv, m_mv;

  function automatic logic [1:0] pick(input logic [RW-1:0] s);
    if (m_xwe && m_xrd != 0 && m_xrd == s) return 2'b10;
    if (m_mwe && m_mrd != 0 && m_mrd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] val(input logic [1:0] s, input logic [DW-1:0] rf);
    return (s == 2'b10) ? m_xv : (s == 2'b01) ? m_mv : rf;
  endfunction

  task automatic step(input logic adv, input logic we, input logic [RW-1:0] rd,
                      input logic [DW-1:0] res, input logic ld, input logic [DW-1:0] ldd,
                      input logic [RW-1:0] sa, input logic [RW-1:0] sb,
                      input logic [RW-1:0] ss, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    stepno++;
    adv_i = adv; ex_we_i = we; ex_rd_i = rd; ex_res_i = res; ex_ld_i = ld;
    ld_data_i = ldd; src_a_i = sa; src_b_i = sb; src_s_i = ss;
    rf_a_i = {32'hAAAA_0000, 32'(stepno)};
    rf_b_i = {32'hBBBB_0000, 32'(stepno)};
    rf_s_i = {32'h5555_0000, 32'(stepno)};
    e.sa = pick(sa); e.sb = pick(sb); e.ss = pick(ss);
    e.oa = val(e.sa, rf_a_i); e.ob = val(e.sb, rf_b_i); e.os = val(e.ss, rf_s_i);
    e.tag = tag;
    q.push_back(e);
    if (adv) begin
      m_mwe = m_xwe; m_mrd = m_xrd; m_mv = m_xld ? ldd : m_xv;
      m_xwe = we; m_xrd = rd; m_xv = res; m_xld = ld;
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pop and compare while the driven inputs are settled
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "sel_a", 64'(sel_a_o), 64'(e.sa));
        chk(e.tag, "sel_b", 64'(sel_b_o), 64'(e.sb));
        chk(e.tag, "sel_s", 64'(sel_s_o), 64'(e.ss));
        chk(e.tag, "opnd_a", opnd_a_o, e.oa);
        chk(e.tag, "opnd_b", opnd_b_o, e.ob);
        chk(e.tag, "opnd_s", opnd_s_o, e.os);
      end
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    m_xwe = 0; m_mwe = 0; m_xld = 0; m_xrd = 0; m_mrd = 0; m_xv = 0; m_mv = 0;
    rst_n = 0; adv_i = 0; ex_we_i = 0; ex_ld_i = 0; ex_rd_i = 0; ex_res_i = 0;
    ld_data_i = 0; src_a_i = 0; src_b_i = 0; src_s_i = 0;
    rf_a_i = 0; rf_b_i = 0; rf_s_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: nothing held after reset
    step(0, 0, 0, 0, 0, 0, 5'd1, 5'd2, 5'd3, "R1");
    // producer r3, then read it from EX/MEM (R2) on A and store (R7)
    step(1, 1, 5'd3, 64'h3333_0000_0000_0001, 0, 0, 5'd9, 5'd9, 5'd9, "R10");
    step(1, 1, 5'd4, 64'h4444_0000_0000_0002, 0, 0, 5'd3, 5'd1, 5'd3, "R2 R7");
    // r3 now in MEM/WB, r4 in EX/MEM: R3 on B
    step(1, 1, 5'd5, 64'h5555_AAAA_0000_0003, 0, 0, 5'd4, 5'd3, 5'd4, "R3");
    // second write to r5: both stages hold r5 -> younger wins (R4)
    step(1, 1, 5'd5, 64'h5555_BBBB_0000_0004, 0, 0, 5'd1, 5'd5, 5'd2, "R2");
    step(1, 0, 5'd6, 64'h6666_0000_0000_0005, 0, 0, 5'd5, 5'd5, 5'd5, "R4");
    // we=0 producer r6 (R5), then rd=0 producer (R6)
    step(1, 1, 5'd0, 64'h0000_DEAD_0000_0006, 0, 0, 5'd6, 5'd6, 5'd6, "R5");
    step(1, 0, 5'd0, 0, 0, 0, 5'd0, 5'd0, 5'd0, "R6");
    step(1, 0, 5'd0, 0, 0, 0, 5'd0, 5'd0, 5'd6, "R6 R5");
    // load to r8: ALU output is an address, memory data must be forwarded (R8)
    step(1, 1, 5'd8, 64'h0000_0000_0000_1000, 1, 0, 5'd1, 5'd1, 5'd1, "R10");
    step(1, 0, 5'd0, 0, 0, 64'hF00D_F00D_1234_5678, 5'd8, 5'd2, 5'd8, "R2");
    step(0, 0, 5'd0, 0, 0, 0, 5'd8, 5'd8, 5'd8, "R8");
    // hold: inputs toggle but adv low (R9)
    step(0, 1, 5'd8, 64'hBAD0_BAD0_BAD0_BAD0, 0, 64'hBAD1, 5'd8, 5'd8, 5'd7, "R9");
    step(0, 1, 5'd7, 64'hBAD2, 1, 64'hBAD3, 5'd8, 5'd7, 5'd8, "R9");
    // store path with MEM/WB producer (R7)
    step(1, 1, 5'd12, 64'hC0C0_0000_0000_000C, 0, 0, 5'd2, 5'd2, 5'd2, "R10");
    step(1, 0, 5'd0, 0, 0, 0, 5'd1, 5'd1, 5'd12, "R7");
    step(1, 0, 5'd0, 0, 0, 0, 5'd1, 5'd1, 5'd12, "R7");
    step(0, 0, 5'd0, 0, 0, 0, 5'd31, 5'd30, 5'd12, "R10");
    repeat (3) @(posedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    finish_up();
  end
endmodule